// File: doc/BRIEF.md
# Tapped Fourteen-Stage Clock Divider

This block divides an incoming clock by successive powers of two through a fourteen-stage binary chain. The chain advances on the falling edge of `clk_i`. Only some stage outputs leave the block, as frequency taps. An asynchronous active-high reset clears every stage at once. The same reset also gates off the clock source that feeds the chain, which models a stand-by state. That source is an enable, not an oscillator, and it is visible on `clk_en_o`.

The chain is built as one synchronous counter clocked on the negative edge, so no stage clocks the next. The taps are slices of that counter, chosen by a stage mask parameter. A second parameter picks how the count logic is formed: a single incrementer, or per-stage toggle cells with a carry chain.

An optional compare output flags one chosen count value. It is registered on the rising clock edge, half a period after the count moves, so a decode of changing stage bits never reaches the port as a spike.

Top module: `tapped_clock_divider`

## Requirements
- R1: While `rst_i` is low, every falling edge of `clk_i` raises the count by exactly one, and rising edges leave the taps unchanged.
- R2: The first falling edge after `rst_i` is released produces a count of 1. With `MATCH_VAL` = 1 this shows on `match_o` at the next rising edge, and `match_o` drops again one period later.
- R3: Raising `rst_i` forces every tap and `match_o` low immediately, with no clock edge needed.
- R4: While `rst_i` is high, clock edges are ignored, the taps stay zero and `clk_en_o` is low. While `rst_i` is low, `clk_en_o` is high.
- R5: Stage n is count bit n-1. Under the default mask 32'h3BF8, `taps_o[6:0]` carry stages 4 to 10 in ascending order and `taps_o[9:7]` carry stages 12 to 14. Stages 1 to 3 and 11 stay internal.
- R6: Stage n has a period of 2^n input clocks. Stage 14 (`taps_o[9]`) is low through falling edge 8191 and first goes high on edge 8192.
- R7: On falling edge 16384 the count wraps from all ones to zero, and no terminal flag is raised.
- R8: With `MATCH_EN` = 1, `match_o` rises on the rising edge that follows the falling edge where the count becomes `MATCH_VAL`. It stays high for exactly one clock period.
- R9: With `MATCH_EN` = 0, `match_o` is held low.
- R10: With `CHAIN_FORM` = 1 (toggle cells with a carry chain), the taps equal those of the default incrementer form on every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock; the chain advances on its falling edge |
| rst_i | input | 1 | Asynchronous active-high reset and stand-by request |
| clk_en_o | output | 1 | High while the clock source feeds the chain |
| taps_o | output | NTAPS (10 by default) | Selected stage outputs, lowest selected stage in bit 0 |
| match_o | output | 1 | Registered flag for count equal to `MATCH_VAL` |

## Verification
The hardest state to reach from the ports is the compare flag at a count far into the sequence, with reset then raised while that flag is high. The bench walks the whole 16384-state cycle plus a margin, so the wrap and the first rise of stage 14 are both reached. After a fresh release it counts exactly up to the compare value of a second instance. It then raises reset in the high phase of the clock, before the next falling edge, to show that both the flag and the taps clear with no clock edge. A third instance uses the toggle-cell chain with the compare disabled, and its taps are checked against the same arithmetic expectation.

// File: rtl/tapdiv_pkg.sv
package tapdiv_pkg;

   localparam int unsigned MASK_W     = 32;
   localparam int unsigned MAX_STAGES = 32;

   // chain construction variants
   localparam int unsigned FORM_ADDER  = 0;
   localparam int unsigned FORM_TOGGLE = 1;

   // number of set bits of mask strictly below bit position upto
   function automatic int unsigned popcount_below(input logic [MASK_W-1:0] mask,
                                                  input int unsigned       upto);
      int unsigned n;
      n = 0;
      for (int unsigned i = 0; i < MASK_W; i++) begin
         if ((i < upto) && mask[i]) n++;
      end
      return n;
   endfunction

   // number of taps brought out for a chain of the given length
   function automatic int unsigned tap_count(input logic [MASK_W-1:0] mask,
                                             input int unsigned       stages);
      return popcount_below(mask, stages);
   endfunction

endpackage

// File: rtl/tapdiv_src_gate.sv
// Stand-by gate of the clock source: the chain only sees edges while
// reset is low. Modelled as an enable, not as a gated clock.
module tapdiv_src_gate (
   input  logic rst_i,
   output logic run_o
);

   assign run_o = ~rst_i;

endmodule

// File: rtl/tapdiv_chain.sv
// Fourteen (STAGES) binary divide-by-two stages, all clocked on the
// falling edge of clk_i; two constructions selected by CHAIN_FORM.
module tapdiv_chain
   import tapdiv_pkg::*;
#(
   parameter int unsigned STAGES     = 14,
   parameter int unsigned CHAIN_FORM = FORM_ADDER
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              run_i,
   output logic [STAGES-1:0] count_o
);

   localparam logic [STAGES-1:0] STEP = {{(STAGES-1){1'b0}}, 1'b1};

   if (CHAIN_FORM == FORM_ADDER) begin : g_adder
      logic [STAGES-1:0] cnt_q;

      always_ff @(negedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            cnt_q <= '0;
         end else if (run_i) begin
            cnt_q <= cnt_q + STEP;
         end
      end

      assign count_o = cnt_q;
   end else begin : g_toggle
      logic [STAGES-1:0] bit_q;
      logic [STAGES-1:0] carry_w;

      assign carry_w[0] = run_i;

      for (genvar s = 0; s < STAGES; s++) begin : g_stage
         if (s > 0) begin : g_carry
            assign carry_w[s] = carry_w[s-1] & bit_q[s-1];
         end

         always_ff @(negedge clk_i or posedge rst_i) begin
            if (rst_i) begin
               bit_q[s] <= 1'b0;
            end else if (carry_w[s]) begin
               bit_q[s] <= ~bit_q[s];
            end
         end
      end

      assign count_o = bit_q;
   end

endmodule

// File: rtl/tapdiv_taps.sv
// Brings out the stages selected by TAP_MASK, lowest selected stage in bit 0.
module tapdiv_taps
   import tapdiv_pkg::*;
#(
   parameter int unsigned       STAGES   = 14,
   parameter logic [MASK_W-1:0] TAP_MASK = 32'h0000_3BF8,
   parameter int unsigned       NTAPS    = 10
) (
   input  logic [STAGES-1:0] count_i,
   output logic [NTAPS-1:0]  taps_o
);

   localparam logic [STAGES-1:0] KEEP = TAP_MASK[STAGES-1:0];

   for (genvar s = 0; s < STAGES; s++) begin : g_sel
      if (KEEP[s]) begin : g_tap
         assign taps_o[popcount_below(TAP_MASK, s)] = count_i[s];
      end
   end

   // stages kept internal
   logic unused_stages;
   assign unused_stages = ^(count_i & ~KEEP);

endmodule

// File: rtl/tapdiv_decode.sv
// Compare of the count against MATCH_VAL, sampled on the rising edge so the
// staggered stage changes of the falling edge never reach the output.
module tapdiv_decode
   import tapdiv_pkg::*;
#(
   parameter int unsigned       STAGES    = 14,
   parameter bit                MATCH_EN  = 1'b1,
   parameter logic [MASK_W-1:0] MATCH_VAL = 32'd4095
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [STAGES-1:0] count_i,
   output logic              match_o
);

   localparam logic [STAGES-1:0] HIT_VAL = MATCH_VAL[STAGES-1:0];

   if (MATCH_EN) begin : g_on
      logic hit_q;

      always_ff @(posedge clk_i or posedge rst_i) begin
         if (rst_i) begin
            hit_q <= 1'b0;
         end else begin
            hit_q <= (count_i == HIT_VAL);
         end
      end

      assign match_o = hit_q;
   end else begin : g_off
      logic unused_dec;
      assign unused_dec = ^{clk_i, rst_i, count_i};
      assign match_o    = 1'b0;
   end

endmodule

// File: rtl/tapped_clock_divider.sv
module tapped_clock_divider
   import tapdiv_pkg::*;
#(
   parameter int unsigned       STAGES     = 14,
   parameter logic [MASK_W-1:0] TAP_MASK   = 32'h0000_3BF8,
   parameter int unsigned       CHAIN_FORM = FORM_ADDER,
   parameter bit                MATCH_EN   = 1'b1,
   parameter logic [MASK_W-1:0] MATCH_VAL  = 32'd4095,
   localparam int unsigned      NTAPS      = tap_count(TAP_MASK, STAGES)
) (
   input  logic             clk_i,
   input  logic             rst_i,
   output logic             clk_en_o,
   output logic [NTAPS-1:0] taps_o,
   output logic             match_o
);

   // elaboration-time parameter checks
   if (STAGES < 2 || STAGES > MAX_STAGES) begin : g_bad_stages
      $error("tapped_clock_divider: STAGES must lie in 2..32");
   end
   if ((STAGES < MASK_W) && ((TAP_MASK >> STAGES) != '0)) begin : g_bad_mask
      $error("tapped_clock_divider: TAP_MASK selects a stage beyond the chain");
   end
   if (NTAPS == 0) begin : g_no_taps
      $error("tapped_clock_divider: TAP_MASK selects no stage");
   end
   if (CHAIN_FORM != FORM_ADDER && CHAIN_FORM != FORM_TOGGLE) begin : g_bad_form
      $error("tapped_clock_divider: unknown CHAIN_FORM");
   end
   if (MATCH_EN && (STAGES < MASK_W) && ((MATCH_VAL >> STAGES) != '0)) begin : g_bad_match
      $error("tapped_clock_divider: MATCH_VAL does not fit the chain");
   end

   logic              run_w;
   logic [STAGES-1:0] count_w;

   tapdiv_src_gate u_gate (
      .rst_i (rst_i),
      .run_o (run_w)
   );

   assign clk_en_o = run_w;

   tapdiv_chain #(
      .STAGES     (STAGES),
      .CHAIN_FORM (CHAIN_FORM)
   ) u_chain (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .run_i   (run_w),
      .count_o (count_w)
   );

   tapdiv_taps #(
      .STAGES   (STAGES),
      .TAP_MASK (TAP_MASK),
      .NTAPS    (NTAPS)
   ) u_taps (
      .count_i (count_w),
      .taps_o  (taps_o)
   );

   tapdiv_decode #(
      .STAGES    (STAGES),
      .MATCH_EN  (MATCH_EN),
      .MATCH_VAL (MATCH_VAL)
   ) u_dec (
      .clk_i   (clk_i),
      .rst_i   (rst_i),
      .count_i (count_w),
      .match_o (match_o)
   );

endmodule

// File: rtl/tapdiv_chk.sv
module tapdiv_chk
   import tapdiv_pkg::*;
#(
   parameter int unsigned       STAGES    = 14,
   parameter int unsigned       NTAPS     = 10,
   parameter bit                MATCH_EN  = 1'b1,
   parameter logic [MASK_W-1:0] MATCH_VAL = 32'd4095
) (
   input logic              clk_i,
   input logic              rst_i,
   input logic              run_i,
   input logic [STAGES-1:0] cnt_i,
   input logic [NTAPS-1:0]  taps_i,
   input logic              match_i
);

   localparam logic [STAGES-1:0] ONE = {{(STAGES-1){1'b0}}, 1'b1};
   localparam logic [STAGES-1:0] HIT = MATCH_VAL[STAGES-1:0];

   AST_COUNT_STEP: assert property (@(negedge clk_i) disable iff (rst_i)
      run_i |=> ((cnt_i - $past(cnt_i)) == ONE)) else $error("count step"); // R1

   AST_RESET_CLEAR: assert property (@(posedge clk_i)
      rst_i |-> ((taps_i == '0) && !match_i)) else $error("reset clear"); // R3

   AST_STANDBY_IDLE: assert property (@(posedge clk_i)
      !run_i |-> (cnt_i == '0)) else $error("standby idle"); // R4

   if (MATCH_EN) begin : g_match_on
      AST_MATCH_ALIGNED: assert property (@(negedge clk_i) disable iff (rst_i)
         match_i |-> (cnt_i == HIT)) else $error("match aligned"); // R8
   end else begin : g_match_off
      AST_MATCH_OFF: assert property (@(posedge clk_i)
         !match_i) else $error("match off"); // R9
   end

endmodule

bind tapped_clock_divider tapdiv_chk #(
   .STAGES    (STAGES),
   .NTAPS     (NTAPS),
   .MATCH_EN  (MATCH_EN),
   .MATCH_VAL (MATCH_VAL)
) u_chk (
   .clk_i   (clk_i),
   .rst_i   (rst_i),
   .run_i   (clk_en_o),
   .cnt_i   (count_w),
   .taps_i  (taps_o),
   .match_i (match_o)
);

// File: tb/test_tapped_clock_divider.sv
`timescale 1ns/1ps
module test_tapped_clock_divider;

   localparam int unsigned MB     = 12345;
   localparam int unsigned PERIOD = 16384;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en_a, en_b, en_c;
   logic [9:0] taps_a, taps_b, taps_c;
   logic       match_a, match_b, match_c;

   int unsigned n_chk = 0;
   int unsigned n_bad = 0;
   bit          done  = 1'b0;

   always #5 clk = ~clk;

   tapped_clock_divider #(.MATCH_VAL(32'd1)) i_tapped_clock_divider (
      .clk_i(clk), .rst_i(rst), .clk_en_o(en_a), .taps_o(taps_a), .match_o(match_a));

   tapped_clock_divider #(.MATCH_VAL(MB)) i_tapped_clock_divider_b (
      .clk_i(clk), .rst_i(rst), .clk_en_o(en_b), .taps_o(taps_b), .match_o(match_b));

   tapped_clock_divider #(.CHAIN_FORM(1), .MATCH_EN(1'b0)) i_tapped_clock_divider_c (
      .clk_i(clk), .rst_i(rst), .clk_en_o(en_c), .taps_o(taps_c), .match_o(match_c));

   function automatic logic [9:0] exp_taps(input int unsigned e);
      logic [13:0] v;
      v = e[13:0];
      return {v[13:11], v[9:3]};
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      #2_000_000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [9:0] held;
      // reset state; edges during reset are ignored (R4)
      repeat (3) @(posedge clk);
      #2;
      chk("R3", taps_a, 0);
      chk("R3", match_a, 0);
      chk("R4", en_a, 0);
      chk("R4", taps_c, 0);

      rst = 1'b0;
      #1;
      chk("R4", en_a, 1);
      chk("R4", en_b, 1);

      // full cycle sweep plus margin
      for (int unsigned k = 1; k <= PERIOD + 16; k++) begin
         int unsigned e;
         e = k % PERIOD;
         @(negedge clk);
         #2;
         chk("R1", taps_a, exp_taps(e));
         chk("R8", match_b, (k >= 2) && (((k - 1) % PERIOD) == MB));
         held = taps_a;
         @(posedge clk);
         #2;
         chk("R1", taps_a, held);
         chk("R5", taps_a, exp_taps(e));
         chk("R10", taps_c, exp_taps(e));
         chk("R8", match_a, e == 1);
         chk("R8", match_b, e == MB);
         chk("R9", match_c, 0);
         if (k == 1) begin
            chk("R2", match_a, 1);
            chk("R2", taps_a, 0);
         end
         if (k == 2) chk("R2", match_a, 0);
         if (k == 8191) chk("R6", taps_a[9], 0);
         if (k == 8192) chk("R6", taps_a[9], 1);
         if (k == 8) chk("R6", taps_a[0], 1);
         if (k == 16) chk("R6", taps_a[0], 0);
         if (k == PERIOD - 1) chk("R7", taps_a, 10'h3FF);
         if (k == PERIOD) chk("R7", taps_a, 0);
      end

      // asynchronous reset in the low phase, then hold in stand-by
      @(negedge clk);
      #2;
      rst = 1'b1;
      #1;
      chk("R3", taps_a, 0);
      chk("R4", en_a, 0);
      for (int i = 0; i < 4; i++) begin
         @(posedge clk);
         #2;
         chk("R4", taps_a, 0);
         chk("R4", taps_c, 0);
         chk("R4", en_c, 0);
      end

      // fresh release, count up to the compare value of instance b
      rst = 1'b0;
      for (int unsigned k = 1; k <= MB; k++) begin
         @(negedge clk);
         @(posedge clk);
         #2;
         if (k == 1) chk("R2", match_a, 1);
         if (k == 2) chk("R2", match_a, 0);
      end
      chk("R8", match_b, 1);
      chk("R5", taps_b, exp_taps(MB));
      #1;
      rst = 1'b1;
      #1;
      chk("R3", match_b, 0);
      chk("R3", taps_b, 0);
      chk("R4", en_b, 0);

      @(posedge clk);
      #2;
      finish_run();
   end

endmodule